// File: doc/BRIEF.md
# Century Rollover Detector

This block sits next to a two-digit BCD year counter in the always-powered clock domain. It watches for the moment the year moves from 99 to 00. When the year-advance strobe is high and the year still reads 99, the block sets a sticky century status flag. The flag stays set until software clears it by writing a one to its bit in a status word.

The block produces a system-management interrupt request as a level. The request is high only when the flag is set, the system is in the running power state, and the interrupt is enabled. If the wrap happens while the system sleeps, the flag is still captured, but no request is raised and nothing wakes the system. When the system later returns to the running state for some other reason, the pending flag drives the request straight away. Firmware then advances the century byte, which this block does not hold, and clears the flag.

Top module: `cent_rollover_top`

## Requirements
- R1: After a synchronous reset, `cent_flag` and `smi_req` are both 0.
- R2: A clock edge with `year_adv`=1 and `year_bcd`=8'h99 (every BCD digit equal to 9) sets `cent_flag` in that same edge.
- R3: An edge where `year_adv`=0, or where `year_bcd` is not 8'h99, does not set `cent_flag`.
- R4: Once set, `cent_flag` stays 1 until an edge with `stat_wr`=1 and `stat_wdata[12]`=1, which clears it.
- R5: A status write with `stat_wdata[12]`=0 leaves `cent_flag` unchanged, whatever the other data bits hold.
- R6: When a rollover and a clearing write happen on the same edge, `cent_flag` ends up 1.
- R7: `smi_req` is registered. After each edge it equals the new `cent_flag` AND (`pwr_state`==0) AND `irq_en`, where the last two are the values sampled at that edge. Power-state code 0 is the running state and codes 1 to 5 are sleep states.
- R8: While `pwr_state` is not 0, a rollover sets `cent_flag` and `smi_req` stays 0. There is no wake output of any kind.
- R9: A flag left pending from sleep asserts `smi_req` at the first edge where `pwr_state` is sampled as 0 with `irq_en`=1.
- R10: With `irq_en`=0, a rollover still sets `cent_flag` and `smi_req` stays 0.
- R11: Clearing the flag drops `smi_req` on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-powered domain clock |
| rst | input | 1 | Synchronous active-high reset |
| year_adv | input | 1 | One-cycle strobe: the year counter advances at this edge |
| year_bcd | input | 8 | Current BCD year, two digits |
| pwr_state | input | 3 | Power state: 0 running, 1 to 5 sleep |
| irq_en | input | 1 | Interrupt enable for the century event |
| stat_wr | input | 1 | Status word write strobe |
| stat_wdata | input | 16 | Status write data; bit 12 is write-one-to-clear for the flag |
| cent_flag | output | 1 | Sticky century status flag |
| smi_req | output | 1 | System-management interrupt request level |

## Verification
Directed patterns cover the following cases:
- near misses: a strobe with year 98, and year 99 with no strobe;
- a rollover in the running state, against one in sleep followed by a return to running;
- a clear that coincides with a wrap, and a write with bit 12 low;
- the enable held low.

Each pattern separates a missing gate from a wrong priority. A firmware model steps a BCD year through 97→00 and advances a century byte on each interrupt, which shows the event is seen exactly once. A long seeded random run then mixes strobes, sleep codes, enables and writes, and compares every cycle against a reference model.

// File: rtl/cent_pkg.sv
package cent_pkg;
  localparam int PWR_W = 3;

  typedef enum logic [PWR_W-1:0] {
    PWR_RUN = 3'd0,
    PWR_S1  = 3'd1,
    PWR_S2  = 3'd2,
    PWR_S3  = 3'd3,
    PWR_S4  = 3'd4,
    PWR_S5  = 3'd5
  } pwr_e;
endpackage

// File: rtl/cent_wrap_detect.sv
module cent_wrap_detect #(
  parameter int DIGITS = 2,
  localparam int YW = 4 * DIGITS
) (
  input  logic          adv,
  input  logic [YW-1:0] year,
  output logic          wrap
);
  logic [DIGITS-1:0] digit_top;

  // A wrap is due when every BCD digit sits at its maximum, 9.
  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    assign digit_top[d] = (year[4*d +: 4] == 4'h9);
  end

  assign wrap = adv & (&digit_top);
endmodule

// File: rtl/cent_status_reg.sv
module cent_status_reg #(
  parameter int STAT_W   = 16,
  parameter int STAT_BIT = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set,
  input  logic              wr,
  input  logic [STAT_W-1:0] wdata,
  output logic              flag_q,
  output logic              flag_nxt
);
  localparam logic [STAT_W-1:0] CLR_MASK = STAT_W'(1) << STAT_BIT;

  logic [STAT_W-1:0] hit;
  logic              clr;

  assign hit      = wdata & CLR_MASK;
  assign clr      = wr & (|hit);
  // A set wins over a clear on the same edge.
  assign flag_nxt = set | (flag_q & ~clr);

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= flag_nxt;
  end

  assert_set_R2: assert property (@(posedge clk) disable iff (rst)
    set |=> flag_q);
  assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !flag_q);
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!clr && !set) |=> $stable(flag_q));
  assert_prio_R6: assert property (@(posedge clk) disable iff (rst)
    (clr && set) |=> flag_q);
endmodule

// File: rtl/cent_irq_gate.sv
module cent_irq_gate
  import cent_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             flag_nxt,
  input  logic [PWR_W-1:0] pwr,
  input  logic             en,
  output logic             irq_q
);
  logic running;

  assign running = (pwr == PWR_RUN);

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= flag_nxt & running & en;
  end

  assert_sleep_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !running |=> !irq_q);
  assert_enable_R10: assert property (@(posedge clk) disable iff (rst)
    !en |=> !irq_q);
endmodule

// File: rtl/cent_rollover_top.sv
module cent_rollover_top
  import cent_pkg::*;
#(
  parameter int DIGITS   = 2,
  parameter int STAT_W   = 16,
  parameter int STAT_BIT = 12,
  localparam int YW = 4 * DIGITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              year_adv,
  input  logic [YW-1:0]     year_bcd,
  input  logic [PWR_W-1:0]  pwr_state,
  input  logic              irq_en,
  input  logic              stat_wr,
  input  logic [STAT_W-1:0] stat_wdata,
  output logic              cent_flag,
  output logic              smi_req
);
  logic wrap;
  logic flag_nxt;

  cent_wrap_detect #(.DIGITS(DIGITS)) u_detect (
    .adv  (year_adv),
    .year (year_bcd),
    .wrap (wrap)
  );

  cent_status_reg #(.STAT_W(STAT_W), .STAT_BIT(STAT_BIT)) u_status (
    .clk      (clk),
    .rst      (rst),
    .set      (wrap),
    .wr       (stat_wr),
    .wdata    (stat_wdata),
    .flag_q   (cent_flag),
    .flag_nxt (flag_nxt)
  );

  cent_irq_gate u_gate (
    .clk      (clk),
    .rst      (rst),
    .flag_nxt (flag_nxt),
    .pwr      (pwr_state),
    .en       (irq_en),
    .irq_q    (smi_req)
  );

  assert_no_spurious_R3: assert property (@(posedge clk) disable iff (rst)
    !(year_adv && (year_bcd == {DIGITS{4'h9}})) |=> !$rose(cent_flag));
  assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (rst)
    smi_req |-> cent_flag);
  assert_clear_drops_irq_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(cent_flag) |-> !smi_req);
endmodule

// File: tb/cent_rollover_top_tb.sv
module cent_rollover_top_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        year_adv;
  logic [7:0]  year_bcd;
  logic [2:0]  pwr_state;
  logic        irq_en;
  logic        stat_wr;
  logic [15:0] stat_wdata;
  logic        cent_flag;
  logic        smi_req;

  int checks   = 0;
  int failures = 0;
  logic m_flag = 1'b0;
  logic m_irq  = 1'b0;
  logic [7:0] century;
  logic [7:0] yr;

  always #10 clk = ~clk;

  cent_rollover_top u_dut (
    .clk(clk), .rst(rst), .year_adv(year_adv), .year_bcd(year_bcd),
    .pwr_state(pwr_state), .irq_en(irq_en), .stat_wr(stat_wr),
    .stat_wdata(stat_wdata), .cent_flag(cent_flag), .smi_req(smi_req)
  );

  function automatic logic f_flag(logic cur, logic adv, logic [7:0] y,
                                  logic wr, logic [15:0] wd);
    return (adv && y == 8'h99) || (cur && !(wr && wd[12]));
  endfunction

  function automatic logic f_irq(logic nf, logic [2:0] p, logic en);
    return nf && (p == 3'd0) && en;
  endfunction

  function automatic logic [7:0] bcd_inc(logic [7:0] v);
    if (v[3:0] == 4'h9) return (v[7:4] == 4'h9) ? 8'h00 : {v[7:4] + 4'h1, 4'h0};
    return {v[7:4], v[3:0] + 4'h1};
  endfunction

  task automatic chk(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0b exp=%0b t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(logic adv, logic [7:0] y, logic [2:0] p, logic en,
                      logic wr, logic [15:0] wd);
    @(negedge clk);
    year_adv = adv; year_bcd = y; pwr_state = p; irq_en = en;
    stat_wr = wr; stat_wdata = wd;
    m_flag = f_flag(m_flag, adv, y, wr, wd);
    m_irq  = f_irq(m_flag, p, en);
    @(posedge clk);
    #2;
  endtask

  task automatic idle(logic [2:0] p, logic en);
    step(1'b0, 8'h12, p, en, 1'b0, 16'h0);
  endtask

  task automatic clear_flag();
    step(1'b0, 8'h12, 3'd0, 1'b1, 1'b1, 16'h1000);
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0C21));
    rst = 1'b1; year_adv = 0; year_bcd = 0; pwr_state = 0; irq_en = 1;
    stat_wr = 0; stat_wdata = 0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 flag after reset", cent_flag, 1'b0);
    chk("R1 irq after reset", smi_req, 1'b0);
    @(negedge clk); rst = 1'b0;

    step(1'b1, 8'h98, 3'd0, 1'b1, 1'b0, 16'h0);
    chk("R3 strobe year 98", cent_flag, 1'b0);
    step(1'b0, 8'h99, 3'd0, 1'b1, 1'b0, 16'h0);
    chk("R3 year 99 no strobe", cent_flag, 1'b0);
    step(1'b1, 8'h09, 3'd0, 1'b1, 1'b0, 16'h0);
    chk("R3 strobe year 09", cent_flag, 1'b0);

    step(1'b1, 8'h99, 3'd0, 1'b1, 1'b0, 16'h0);
    chk("R2 rollover sets flag", cent_flag, 1'b1);
    chk("R7 irq with flag active", smi_req, 1'b1);
    idle(3'd0, 1'b1);
    chk("R4 flag sticky", cent_flag, 1'b1);
    step(1'b0, 8'h12, 3'd0, 1'b1, 1'b1, 16'hEFFF);
    chk("R5 write bit12=0 keeps flag", cent_flag, 1'b1);
    chk("R5 write bit12=0 keeps irq", smi_req, 1'b1);
    clear_flag();
    chk("R4 w1c clears flag", cent_flag, 1'b0);
    chk("R11 clear drops irq", smi_req, 1'b0);

    step(1'b1, 8'h99, 3'd3, 1'b1, 1'b0, 16'h0);
    chk("R8 sleep rollover sets flag", cent_flag, 1'b1);
    chk("R8 sleep no irq", smi_req, 1'b0);
    idle(3'd5, 1'b1);
    idle(3'd1, 1'b1);
    chk("R8 still no irq in sleep", smi_req, 1'b0);
    idle(3'd0, 1'b1);
    chk("R9 pending flag irq on wake", smi_req, 1'b1);
    clear_flag();

    step(1'b1, 8'h99, 3'd0, 1'b0, 1'b0, 16'h0);
    chk("R10 disabled flag set", cent_flag, 1'b1);
    chk("R10 disabled no irq", smi_req, 1'b0);
    idle(3'd0, 1'b1);
    chk("R7 enable raises irq", smi_req, 1'b1);
    clear_flag();

    step(1'b1, 8'h99, 3'd0, 1'b1, 1'b1, 16'hFFFF);
    chk("R6 set beats clear", cent_flag, 1'b1);
    clear_flag();
    chk("R4 cleared before firmware run", cent_flag, 1'b0);

    // Firmware model: year walks 97 -> 00, century byte advances on interrupt.
    century = 8'h20; yr = 8'h97;
    for (int i = 0; i < 4; i++) begin
      step(1'b1, yr, 3'd0, 1'b1, 1'b0, 16'h0);
      yr = bcd_inc(yr);
      if (smi_req) begin
        century = bcd_inc(century);
        clear_flag();
      end
    end
    checks++;
    if (century !== 8'h21 || yr !== 8'h01) begin
      failures++;
      $display("FAIL R2 century=%h yr=%h exp=21/01", century, yr);
    end

    // Seeded random mix against the reference model.
    for (int i = 0; i < 4000; i++) begin
      logic adv, en, wr;
      logic [7:0] y;
      logic [2:0] p;
      logic [15:0] wd;
      adv = ($urandom % 4) == 0;
      y   = (($urandom % 3) == 0) ? 8'h99 : 8'($urandom);
      p   = (($urandom % 2) == 0) ? 3'd0 : 3'(1 + $urandom % 5);
      en  = ($urandom % 4) != 0;
      wr  = ($urandom % 6) == 0;
      wd  = 16'($urandom);
      step(adv, y, p, en, wr, wd);
      chk("R7 random flag", cent_flag, m_flag);
      chk("R7 random irq", smi_req, m_irq);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule